// File: doc/BRIEF.md
# Half-Bridge Gate Command Arbiter

This block turns two switch commands into gate-on outputs for the low-side and high-side switches of a half-bridge. It sits between the controller that issues the commands and the gate drivers. Along the way it applies every protection condition that is allowed to veto a command. Three conditions block both switches: the enable input being low (standby), a supply undervoltage flag, and an overtemperature flag. An interlock stops the two switches from ever conducting together. The command that became active first keeps control until it is released. An overcurrent flag on either side turns off only that side's switch, and the switch stays off until its command has been released.

The high side is stricter than the low side. It turns on only on a rising edge of its command that arrives while no global block is present. A switch turn-on that begins partway through a command pulse is therefore never produced. The low side follows its command level and comes back on as soon as every blocking condition has cleared. All fault inputs are synchronous, already-filtered flags. Both outputs are registered.

Top module: `hb_gate_arbiter`

## Requirements
- R1: Both gate outputs are 0 while `rst` is 1 and until the first clock edge after it is released. A high-side command that is held at 1 through reset is not a rising edge: the high side stays off until that command has been sampled 0 and then 1.
- R2: When a clock edge samples `en_i`=0, `flt_uv_i`=1 or `flt_ot_i`=1, both gate outputs are 0 after that edge, whatever the commands are.
- R3: When one command is 1 and the other is 0, that command owns the interlock. It keeps ownership while it stays at 1, even after the other command rises. The non-owning side's gate output stays 0 for as long as it does not own the interlock.
- R4: When both commands go from 0 to 1 on the same clock edge, neither owns the interlock. Both gate outputs stay 0 until one of the two commands returns to 0.
- R5: The low-side gate output is 1 after an edge only if that edge samples `cmd_lo_i`=1, low-side ownership, no global block and no latched low-side overcurrent. With the command held at 1, it turns on again on the first edge at which the global block is gone.
- R6: The high side is armed only by an edge that samples `cmd_hi_i`=1 after a previous sample of 0, with no global block and no high-side overcurrent present. A global block sampled while the command is held at 1 disarms it, and the high side then stays off until the command's next rising edge. An armed high side drives its gate to 1 whenever it owns the interlock.
- R7: An edge that samples `flt_oc_lo_i`=1 turns the low-side gate off at that edge. It stays off, even after the flag clears, until an edge samples `cmd_lo_i`=0.
- R8: An edge that samples `flt_oc_hi_i`=1 turns the high-side gate off at that edge. It stays off until the command has been released and has risen again.
- R9: The two gate outputs are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | 1 = active, 0 = standby (global block) |
| cmd_lo_i | input | 1 | Low-side switch command, 1 = on |
| cmd_hi_i | input | 1 | High-side switch command, 1 = on |
| flt_uv_i | input | 1 | Supply undervoltage flag (global block) |
| flt_ot_i | input | 1 | Overtemperature flag (global block) |
| flt_oc_lo_i | input | 1 | Low-side overcurrent flag |
| flt_oc_hi_i | input | 1 | High-side overcurrent flag |
| gate_lo_o | output | 1 | Registered low-side gate-on |
| gate_hi_o | output | 1 | Registered high-side gate-on |

## Verification
The case that needs the most care is when a rising edge of the high-side command and the start or end of a global block land in the same cycle. The edge qualification and the global veto both decide the high-side arm in that one cycle. The directed part sets up that case, and it also puts simultaneous command rises against the interlock handover. The random part toggles commands and sprinkles short fault pulses, so the same collisions recur in many orders. Every cycle is judged against a cycle-level model built from the requirements, and the no-overlap rule is checked on each comparison.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_LO   = 2'd1,
    OWN_HI   = 2'd2
  } owner_e;
endpackage

// File: rtl/hb_interlock.sv
// Shoot-through interlock: the command that is active alone takes control
// and keeps it while it stays active; simultaneous assertion leaves no owner.
module hb_interlock
  import hb_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_lo,
  input  logic cmd_hi,
  output logic own_lo,
  output logic own_hi
);
  owner_e owner_q;
  owner_e owner_n;

  always_comb begin
    if (cmd_lo && cmd_hi)
      owner_n = owner_q;          // contention: whoever held control keeps it
    else if (cmd_lo)
      owner_n = OWN_LO;
    else if (cmd_hi)
      owner_n = OWN_HI;
    else
      owner_n = OWN_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)
      owner_q <= OWN_NONE;
    else
      owner_q <= owner_n;
  end

  // ownership seen by the gate stages is the value being registered this edge
  assign own_lo = (owner_n == OWN_LO);
  assign own_hi = (owner_n == OWN_HI);
endmodule

// File: rtl/hb_side_qual.sv
// One switch's qualification stage. EDGE_QUAL selects between a level-follow
// side with an overcurrent latch and an edge-armed side.
module hb_side_qual #(
  parameter bit EDGE_QUAL   = 1'b0,
  parameter bit CMD_RST_VAL = 1'b1   // command history value after reset
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  logic gblk,
  input  logic oc,
  input  logic own,
  output logic gate_q
);
  logic gate_n;

  generate
    if (EDGE_QUAL) begin : g_edge
      logic cmd_q;
      logic arm_q;
      logic arm_n;
      logic rise;

      assign rise  = cmd & ~cmd_q;
      // arming needs a clean rising edge; a block or overcurrent disarms
      assign arm_n = cmd & ~gblk & ~oc & (arm_q | rise);

      always_ff @(posedge clk) begin
        if (rst) begin
          cmd_q <= CMD_RST_VAL;
          arm_q <= 1'b0;
        end else begin
          cmd_q <= cmd;
          arm_q <= arm_n;
        end
      end

      assign gate_n = arm_n & own;
    end else begin : g_level
      logic lat_q;
      logic lat_n;

      // overcurrent latch released only by the command going inactive
      assign lat_n = cmd & (lat_q | oc);

      always_ff @(posedge clk) begin
        if (rst)
          lat_q <= 1'b0;
        else
          lat_q <= lat_n;
      end

      assign gate_n = cmd & own & ~gblk & ~lat_n;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      gate_q <= 1'b0;
    else
      gate_q <= gate_n;
  end
endmodule

// File: rtl/hb_gate_arbiter.sv
module hb_gate_arbiter #(
  parameter bit LO_EDGE_QUAL = 1'b0,
  parameter bit HI_EDGE_QUAL = 1'b1,
  parameter bit CMD_RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic cmd_lo_i,
  input  logic cmd_hi_i,
  input  logic flt_uv_i,
  input  logic flt_ot_i,
  input  logic flt_oc_lo_i,
  input  logic flt_oc_hi_i,
  output logic gate_lo_o,
  output logic gate_hi_o
);
  logic gblk;
  logic own_lo;
  logic own_hi;

  // conditions that hold both switches off
  assign gblk = ~en_i | flt_uv_i | flt_ot_i;

  hb_interlock u_ilk (
    .clk    (clk),
    .rst    (rst),
    .cmd_lo (cmd_lo_i),
    .cmd_hi (cmd_hi_i),
    .own_lo (own_lo),
    .own_hi (own_hi)
  );

  hb_side_qual #(
    .EDGE_QUAL   (LO_EDGE_QUAL),
    .CMD_RST_VAL (CMD_RST_VAL)
  ) u_lo (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd_lo_i),
    .gblk   (gblk),
    .oc     (flt_oc_lo_i),
    .own    (own_lo),
    .gate_q (gate_lo_o)
  );

  hb_side_qual #(
    .EDGE_QUAL   (HI_EDGE_QUAL),
    .CMD_RST_VAL (CMD_RST_VAL)
  ) u_hi (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd_hi_i),
    .gblk   (gblk),
    .oc     (flt_oc_hi_i),
    .own    (own_hi),
    .gate_q (gate_hi_o)
  );
endmodule

// File: rtl/hb_gate_arbiter_chk.sv
module hb_gate_arbiter_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic cmd_lo_i,
  input logic cmd_hi_i,
  input logic flt_uv_i,
  input logic flt_ot_i,
  input logic flt_oc_lo_i,
  input logic flt_oc_hi_i,
  input logic gate_lo_o,
  input logic gate_hi_o
);
  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !(gate_lo_o && gate_hi_o)); // R9

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en_i || flt_uv_i || flt_ot_i) |=> (!gate_lo_o && !gate_hi_o)); // R2

  AST_OC_LO_OFF: assert property (@(posedge clk) disable iff (rst)
    flt_oc_lo_i |=> !gate_lo_o); // R7

  AST_OC_HI_OFF: assert property (@(posedge clk) disable iff (rst)
    flt_oc_hi_i |=> !gate_hi_o); // R8

  AST_LO_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    gate_lo_o |-> $past(cmd_lo_i)); // R5

  AST_HI_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi_o) |-> $past(cmd_hi_i)); // R6

  AST_SIMUL_RISE_OFF: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmd_lo_i) && $rose(cmd_hi_i)) |=> (!gate_lo_o && !gate_hi_o)); // R4
endmodule

bind hb_gate_arbiter hb_gate_arbiter_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .cmd_lo_i    (cmd_lo_i),
  .cmd_hi_i    (cmd_hi_i),
  .flt_uv_i    (flt_uv_i),
  .flt_ot_i    (flt_ot_i),
  .flt_oc_lo_i (flt_oc_lo_i),
  .flt_oc_hi_i (flt_oc_hi_i),
  .gate_lo_o   (gate_lo_o),
  .gate_hi_o   (gate_hi_o)
);

// File: tb/hb_gate_arbiter_tb_top.sv
`timescale 1ns/1ps
module hb_gate_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, lo = 1'b0, hi = 1'b0;
  logic uv = 1'b0, ot = 1'b0, ocl = 1'b0, och = 1'b0;
  logic gate_lo, gate_hi;

  always #2.5 clk = ~clk; // 200 MHz

  hb_gate_arbiter dut_i (
    .clk(clk), .rst(rst), .en_i(en), .cmd_lo_i(lo), .cmd_hi_i(hi),
    .flt_uv_i(uv), .flt_ot_i(ot), .flt_oc_lo_i(ocl), .flt_oc_hi_i(och),
    .gate_lo_o(gate_lo), .gate_hi_o(gate_hi)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // requirement-level model state: 0 none, 1 low owns, 2 high owns
  int  m_own;
  bit  m_lat_lo, m_arm_hi, m_prev_hi;
  bit  exp_lo, exp_hi;

  function automatic int next_owner(bit l, bit h, int cur);
    if (l && h) return cur;
    if (l) return 1;
    if (h) return 2;
    return 0;
  endfunction

  task automatic model_reset();
    m_own = 0; m_lat_lo = 0; m_arm_hi = 0; m_prev_hi = 1; // R1: held cmd is no edge
    exp_lo = 0; exp_hi = 0;
  endtask

  task automatic model_edge();
    bit blk;
    int own_n;
    blk       = !en || uv || ot;
    own_n     = next_owner(lo, hi, m_own);
    m_lat_lo  = lo && (m_lat_lo || ocl);
    m_arm_hi  = hi && !blk && !och && (m_arm_hi || (hi && !m_prev_hi));
    m_prev_hi = hi;
    m_own     = own_n;
    exp_lo    = !blk && (own_n == 1) && !m_lat_lo;
    exp_hi    = m_arm_hi && (own_n == 2);
  endtask

  task automatic compare(string tag);
    n_chk++;
    if (gate_lo !== exp_lo || gate_hi !== exp_hi) begin
      n_bad++;
      $display("FAIL %s: gate_lo/hi=%b%b expected %b%b at %0t",
               tag, gate_lo, gate_hi, exp_lo, exp_hi, $time);
    end
    if (gate_lo === 1'b1 && gate_hi === 1'b1) begin
      n_bad++;
      $display("FAIL R9: gate_lo/hi=11 expected not both 1 at %0t", $time);
    end
  endtask

  // compare the outputs of the last edge, then apply the next stimulus
  task automatic step(string tag, bit e, bit l, bit h,
                      bit u, bit t, bit cl, bit ch);
    @(negedge clk);
    compare(tag);
    rst = 0; en = e; lo = l; hi = h; uv = u; ot = t; ocl = cl; och = ch;
    model_edge();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected finish before limit");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit rl, rh;
    void'($urandom(32'h5EED_0042));
    model_reset();
    // R1: reset with high command already asserted
    en = 1; hi = 1;
    repeat (3) begin
      @(negedge clk);
      compare("R1 in reset");
    end
    step("R1", 1,0,1, 0,0,0,0);
    step("R1 held cmd", 1,0,1, 0,0,0,0);
    step("R1 held cmd", 1,0,0, 0,0,0,0);
    // R6: fresh rising edge arms high side
    step("R6", 1,0,1, 0,0,0,0);
    step("R6 on", 1,0,1, 0,0,0,0);
    // R3: low rises while high owns
    step("R3", 1,1,1, 0,0,0,0);
    step("R3 lo blocked", 1,1,1, 0,0,0,0);
    step("R3 handover", 1,1,0, 0,0,0,0);
    step("R3 lo on", 1,0,0, 0,0,0,0);
    // R4: simultaneous rise
    step("R4", 1,1,1, 0,0,0,0);
    step("R4 none", 1,1,1, 0,0,0,0);
    step("R4 none", 1,1,0, 0,0,0,0);
    step("R4 release", 1,1,0, 0,0,0,0);
    // R2 / R5: standby while low held, then recovery
    step("R2 standby", 0,1,0, 0,0,0,0);
    step("R2 off", 1,1,0, 0,0,0,0);
    step("R5 resume", 1,1,0, 0,1,0,0);
    step("R2 overtemp", 1,1,0, 0,0,0,0);
    step("R5 resume", 1,0,0, 0,0,0,0);
    // R6: rise coinciding with undervoltage, clear while held
    step("R6", 1,0,1, 1,0,0,0);
    step("R6 blocked rise", 1,0,1, 0,0,0,0);
    step("R6 stays off", 1,0,1, 0,0,0,0);
    step("R6 stays off", 1,0,0, 0,0,0,0);
    step("R6", 1,0,1, 0,0,0,0);
    step("R6 on", 1,0,1, 1,0,0,0);
    step("R6 cancel", 1,0,1, 0,0,0,0);
    step("R6 stays off", 1,0,0, 0,0,0,0);
    // R7: low overcurrent latch
    step("R7", 1,1,0, 0,0,0,0);
    step("R7 on", 1,1,0, 0,0,1,0);
    step("R7 off", 1,1,0, 0,0,0,0);
    step("R7 latched", 1,1,0, 0,0,0,0);
    step("R7 latched", 1,0,0, 0,0,0,0);
    step("R7 release", 1,1,0, 0,0,0,0);
    step("R7 on again", 1,0,0, 0,0,0,0);
    // R8: high overcurrent latch
    step("R8", 1,0,1, 0,0,0,0);
    step("R8 on", 1,0,1, 0,0,0,1);
    step("R8 off", 1,0,1, 0,0,0,0);
    step("R8 latched", 1,0,0, 0,0,0,0);
    step("R8 release", 1,0,1, 0,0,0,0);
    step("R8 on again", 1,0,1, 0,0,0,0);
    // random phase
    rl = 0; rh = 0;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 6) == 0) rl = !rl;
      if (($urandom % 6) == 0) rh = !rh;
      step("random R2 R3 R5 R6 R7 R8", ($urandom % 24) != 0, rl, rh,
           ($urandom % 40) == 0, ($urandom % 50) == 0,
           ($urandom % 30) == 0, ($urandom % 30) == 0);
    end
    step("final R9", 1,0,0, 0,0,0,0);
    @(negedge clk);
    compare("final");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule